// File: doc/BRIEF.md
# Read Strobe Delay Trimming Engine

This engine nudges the read strobe delay code of every byte lane in a DRAM PHY by a signed amount. It reaches the PHY only through a simple register-bus master port. A start pulse launches one pass. The engine first freezes voltage/temperature tracking in the PHY and waits until the PHY confirms that tracking has stopped. It then walks the lanes one by one, applying a saturating read-modify-write to each lane's 8-bit delay field, and finally releases the freeze.

The bus request works like a valid/ready pair. The engine raises exactly one of `bus_rd_o` or `bus_wr_o`, together with `bus_addr_o` and (for writes) `bus_wdata_o`. It holds all of them stable until it samples `bus_ready_i` high on a rising edge. That edge completes the transfer, and read data is taken from `bus_rdata_i` in the same cycle. The PHY applies back-pressure simply by holding `bus_ready_i` low, and any number of wait cycles is allowed.

The lane count and the step are captured at start. The poll limit caps how long the engine waits for the tracking freeze to be confirmed.

Top module: `rdqs_trim_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `bus_rd_o` and `bus_wr_o` are all 0.
- R2: A start pulse while idle first reads the control register at address 0x0004. It then writes that value back with bit 26 (tracking inhibit) set and every other bit unchanged.
- R3: The engine then reads the status register at 0x000C repeatedly until a read returns bit 30 (tracking stopped) set. No lane register is accessed before that.
- R4: Lane k's delay register lies at 0x01C0 + k*0x0040. For each lane in order 0, 1, …, N-1 the engine performs a read, a write, and a dummy read of that address.
  - N is `lane_cnt_i` captured at start, limited to 4.
  - N = 0 skips the lane phase.
- R5: The written delay field, bits 15:8, equals the old field plus `step_i` (9-bit two's complement), clamped to the range 0..255.
- R6: All bits of the written lane word outside 15:8 equal the word that was read.
- R7: After the last lane, the engine writes the control register with bit 26 cleared and the other bits as first read.
- R8: `done_o` is a one-cycle pulse in the cycle after the final control write is accepted.
- R9: A start pulse while `busy_o` is high is ignored: it causes no extra transfers and no extra `done_o`.
- R10: A status read that returns bit 30 clear counts as a miss. After `poll_limit_i` misses (a limit of 0 acts as 1), `err_o` pulses in the cycle after the last miss is accepted.
  - No lane access follows, and the control register is not restored.
  - `done_o` stays low.
  - The engine returns to idle and accepts a new start.
- R11: `bus_rd_o` and `bus_wr_o` are never high together. A request that is not accepted keeps its strobes, address and write data unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one trimming pass |
| lane_cnt_i | input | CNT_W (3) | Number of byte lanes |
| step_i | input | STEP_W (9) | Signed delay step |
| poll_limit_i | input | POLL_W (16) | Maximum status reads without the stopped flag |
| bus_addr_o | output | ADDR_W (16) | Register address |
| bus_rd_o | output | 1 | Read request |
| bus_wr_o | output | 1 | Write request |
| bus_wdata_o | output | DATA_W (32) | Write data |
| bus_rdata_i | input | DATA_W (32) | Read data, valid while ready is high |
| bus_ready_i | input | 1 | Transfer accepted on this edge |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Pass completed pulse |
| err_o | output | 1 | Freeze confirmation timed out pulse |

## Verification
Every transfer is accepted on a particular rising edge, and the register model in the bench stamps each accepted transfer with its cycle number. The pass is then checked in two ways.
- The ordered transfer log is compared against one built from the requirements.
- The completion pulses are timed against that log. `done_o` must be seen exactly one cycle after the stamp of the final control write, and `err_o` exactly one cycle after the last status read.

Outputs are sampled on the falling edge, so each sample falls half a period after the edge that produced it. Wait states and a start pulse during a pass are included to confirm that these timings hold under back-pressure.

// File: rtl/rdqs_trim_pkg.sv
package rdqs_trim_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CTL_RD,
    S_CTL_SET,
    S_POLL,
    S_LANE_RD,
    S_LANE_WR,
    S_LANE_CHK,
    S_CTL_CLR,
    S_DONE,
    S_FAIL
  } trim_state_e;

endpackage

// File: rtl/rdqs_code_adjust.sv
module rdqs_code_adjust #(
  parameter int DATA_W   = 32,
  parameter int STEP_W   = 9,
  parameter int CODE_LSB = 8,
  parameter int CODE_W   = 8
) (
  input  logic [DATA_W-1:0]        word_i,
  input  logic signed [STEP_W-1:0] step_i,
  output logic [DATA_W-1:0]        word_o
);
  localparam int SUM_W = ((STEP_W > CODE_W) ? STEP_W : CODE_W) + 2;
  localparam logic signed [SUM_W-1:0] CODE_MAX = {{(SUM_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic signed [SUM_W-1:0] code_ext, step_ext, sum;
  logic [CODE_W-1:0] code_new;

  always_comb begin
    code_ext = $signed({{(SUM_W-CODE_W){1'b0}}, word_i[CODE_LSB +: CODE_W]});
    step_ext = $signed({{(SUM_W-STEP_W){step_i[STEP_W-1]}}, step_i});
    sum      = code_ext + step_ext;
    if (sum[SUM_W-1])         code_new = '0;
    else if (sum > CODE_MAX)  code_new = '1;
    else                      code_new = sum[CODE_W-1:0];
    word_o = word_i;
    word_o[CODE_LSB +: CODE_W] = code_new;
  end
endmodule

// File: rtl/rdqs_lane_addr.sv
module rdqs_lane_addr #(
  parameter int ADDR_W      = 16,
  parameter int IDX_W       = 2,
  parameter int LANE_BASE   = 'h01C0,
  parameter int LANE_STRIDE = 'h0040
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam bit POW2 = (LANE_STRIDE > 0) && ((LANE_STRIDE & (LANE_STRIDE - 1)) == 0);
  localparam int SHIFT = (LANE_STRIDE > 1) ? $clog2(LANE_STRIDE) : 0;

  generate
    if (POW2) begin : g_shift
      assign addr_o = ADDR_W'(LANE_BASE) + (ADDR_W'(idx_i) << SHIFT);
    end else begin : g_mult
      assign addr_o = ADDR_W'(LANE_BASE) + ADDR_W'(idx_i) * ADDR_W'(LANE_STRIDE);
    end
  endgenerate
endmodule

// File: rtl/rdqs_poll_timer.sv
module rdqs_poll_timer #(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              miss_i,
  input  logic [POLL_W-1:0] limit_i,
  output logic              expire_o
);
  logic [POLL_W-1:0] cnt_q;
  logic [POLL_W:0]   eff_limit, next_cnt;

  assign eff_limit = (limit_i == '0) ? (POLL_W+1)'(1) : {1'b0, limit_i};
  assign next_cnt  = {1'b0, cnt_q} + (POLL_W+1)'(1);
  assign expire_o  = miss_i && (next_cnt >= eff_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (miss_i && !expire_o)  cnt_q <= next_cnt[POLL_W-1:0];
  end

  // R10: the counter never runs past the limit it guards
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < eff_limit || clear_i || !miss_i);
endmodule

// File: rtl/rdqs_trim_engine.sv
module rdqs_trim_engine
  import rdqs_trim_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int MAX_LANES   = 4,
  parameter int STEP_W      = 9,
  parameter int POLL_W      = 16,
  parameter int CODE_LSB    = 8,
  parameter int CODE_W      = 8,
  parameter int CTL_ADDR    = 'h0004,
  parameter int STS_ADDR    = 'h000C,
  parameter int LANE_BASE   = 'h01C0,
  parameter int LANE_STRIDE = 'h0040,
  parameter int INH_BIT     = 26,
  parameter int VTS_BIT     = 30,
  parameter int CNT_W       = $clog2(MAX_LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         lane_cnt_i,
  input  logic signed [STEP_W-1:0] step_i,
  input  logic [POLL_W-1:0]        poll_limit_i,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic                     bus_rd_o,
  output logic                     bus_wr_o,
  output logic [DATA_W-1:0]        bus_wdata_o,
  input  logic [DATA_W-1:0]        bus_rdata_i,
  input  logic                     bus_ready_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     err_o
);
  localparam int IDX_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;
  localparam logic [DATA_W-1:0] INH_MASK = DATA_W'(1) << INH_BIT;

  trim_state_e state_q, state_d;
  logic [DATA_W-1:0]        ctl_q, word_q, adj_word;
  logic [IDX_W-1:0]         idx_q;
  logic [CNT_W-1:0]         nlanes_q, cnt_cap;
  logic signed [STEP_W-1:0] step_q;
  logic [POLL_W-1:0]        limit_q;
  logic [ADDR_W-1:0]        lane_addr;
  logic acc, vt_set, last_lane, miss, expire, poll_clr;

  rdqs_code_adjust #(.DATA_W(DATA_W), .STEP_W(STEP_W), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W))
    u_adj (.word_i(word_q), .step_i(step_q), .word_o(adj_word));

  rdqs_lane_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANE_BASE(LANE_BASE), .LANE_STRIDE(LANE_STRIDE))
    u_addr (.idx_i(idx_q), .addr_o(lane_addr));

  rdqs_poll_timer #(.POLL_W(POLL_W))
    u_timer (.clk(clk), .rst_n(rst_n), .clear_i(poll_clr), .miss_i(miss),
             .limit_i(limit_q), .expire_o(expire));

  assign acc       = (bus_rd_o || bus_wr_o) && bus_ready_i;
  assign vt_set    = bus_rdata_i[VTS_BIT];
  assign miss      = (state_q == S_POLL) && acc && !vt_set;
  assign poll_clr  = (state_q == S_CTL_SET);
  assign last_lane = (CNT_W'(idx_q) + CNT_W'(1)) == nlanes_q;
  assign cnt_cap   = (lane_cnt_i > CNT_W'(MAX_LANES)) ? CNT_W'(MAX_LANES) : lane_cnt_i;

  // Request decode: one strobe per state, address and data held by state
  always_comb begin
    bus_rd_o    = 1'b0;
    bus_wr_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    case (state_q)
      S_CTL_RD:   begin bus_rd_o = 1'b1; bus_addr_o = ADDR_W'(CTL_ADDR); end
      S_CTL_SET:  begin bus_wr_o = 1'b1; bus_addr_o = ADDR_W'(CTL_ADDR); bus_wdata_o = ctl_q | INH_MASK; end
      S_POLL:     begin bus_rd_o = 1'b1; bus_addr_o = ADDR_W'(STS_ADDR); end
      S_LANE_RD:  begin bus_rd_o = 1'b1; bus_addr_o = lane_addr; end
      S_LANE_WR:  begin bus_wr_o = 1'b1; bus_addr_o = lane_addr; bus_wdata_o = adj_word; end
      S_LANE_CHK: begin bus_rd_o = 1'b1; bus_addr_o = lane_addr; end
      S_CTL_CLR:  begin bus_wr_o = 1'b1; bus_addr_o = ADDR_W'(CTL_ADDR); bus_wdata_o = ctl_q & ~INH_MASK; end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:     if (start_i) state_d = S_CTL_RD;
      S_CTL_RD:   if (acc) state_d = S_CTL_SET;
      S_CTL_SET:  if (acc) state_d = S_POLL;
      S_POLL:     if (acc) begin
                    if (vt_set)      state_d = (nlanes_q == '0) ? S_CTL_CLR : S_LANE_RD;
                    else if (expire) state_d = S_FAIL;
                  end
      S_LANE_RD:  if (acc) state_d = S_LANE_WR;
      S_LANE_WR:  if (acc) state_d = S_LANE_CHK;
      S_LANE_CHK: if (acc) state_d = last_lane ? S_CTL_CLR : S_LANE_RD;
      S_CTL_CLR:  if (acc) state_d = S_DONE;
      S_DONE:     state_d = S_IDLE;
      S_FAIL:     state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ctl_q    <= '0;
      word_q   <= '0;
      idx_q    <= '0;
      nlanes_q <= '0;
      step_q   <= '0;
      limit_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        nlanes_q <= cnt_cap;
        step_q   <= step_i;
        limit_q  <= poll_limit_i;
        idx_q    <= '0;
      end
      if (state_q == S_CTL_RD && acc)   ctl_q  <= bus_rdata_i;
      if (state_q == S_LANE_RD && acc)  word_q <= bus_rdata_i;
      if (state_q == S_LANE_CHK && acc && !last_lane) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);
  assign err_o  = (state_q == S_FAIL);

  // R11: never both strobes
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));
  // R11: unaccepted request is held
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd_o || bus_wr_o) && !bus_ready_i) |=>
      ($stable(bus_rd_o) && $stable(bus_wr_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));
  // R8: done follows an accepted control write that clears the inhibit bit
  p_done_after_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bus_wr_o && bus_ready_i && bus_addr_o == ADDR_W'(CTL_ADDR) && !bus_wdata_o[INH_BIT]));
  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: error follows an accepted status read
  p_err_after_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(bus_rd_o && bus_ready_i && bus_addr_o == ADDR_W'(STS_ADDR)));
  // R9: start during a pass does not end it
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && !err_o && start_i) |=> busy_o);
  // R5: a non-negative step never lowers the delay field
  p_clamp_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LANE_WR && !step_q[STEP_W-1]) |->
      (bus_wdata_o[CODE_LSB +: CODE_W] >= word_q[CODE_LSB +: CODE_W]));
endmodule

// File: tb/sim_rdqs_trim_engine.sv
module sim_rdqs_trim_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CTL_A = 16'h0004;
  localparam logic [15:0] STS_A = 16'h000C;
  localparam int INH = 26;
  localparam int VTS = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] lane_cnt = '0;
  logic signed [8:0] step = '0;
  logic [15:0] limit = '0;
  logic [15:0] addr;
  logic rd, wr, ready, busy, done, err;
  logic [31:0] wdata, rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdqs_trim_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lane_cnt_i(lane_cnt), .step_i(step),
    .poll_limit_i(limit), .bus_addr_o(addr), .bus_rd_o(rd), .bus_wr_o(wr),
    .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ready_i(ready),
    .busy_o(busy), .done_o(done), .err_o(err));

  int checks = 0;
  int errors = 0;

  // register model configuration (written by tasks only)
  logic [31:0] cfg_ctl = 32'h0B1C_0E37;
  logic [31:0] cfg_lane [8];
  int vt_lat = 0;
  int wait_n = 0;
  logic model_load = 1'b0;

  // register model state (written by model only)
  logic [31:0] ctl_reg;
  logic [31:0] lane_reg [8];
  int sts_reads, wcnt, cyc, log_n;
  bit log_wr [64];
  logic [15:0] log_addr [64];
  logic [31:0] log_data [64];
  int log_cyc [64];
  int done_cnt, err_cnt, done_at, err_at, both_cnt;

  function automatic int lane_of(logic [15:0] a);
    int off;
    if (a < 16'h01C0) return -1;
    off = int'(a) - 'h01C0;
    if ((off % 'h40) != 0 || (off / 'h40) > 7) return -1;
    return off / 'h40;
  endfunction

  logic vt_flag;
  assign vt_flag = ctl_reg[INH] && (sts_reads >= vt_lat);
  assign ready = (wcnt >= wait_n);

  always_comb begin
    if (addr == CTL_A)           rdata = ctl_reg;
    else if (addr == STS_A)      rdata = 32'h1 | (32'(vt_flag) << VTS);
    else if (lane_of(addr) >= 0) rdata = lane_reg[lane_of(addr)];
    else                         rdata = 32'hDEAD_BEEF;
  end

  initial begin
    cyc = 0; log_n = 0; wcnt = 0; sts_reads = 0; ctl_reg = '0;
    for (int i = 0; i < 8; i++) begin lane_reg[i] = '0; cfg_lane[i] = '0; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (model_load) begin
      ctl_reg <= cfg_ctl;
      for (int i = 0; i < 8; i++) lane_reg[i] <= cfg_lane[i];
      sts_reads <= 0; log_n <= 0; wcnt <= 0;
    end else if (rst_n && (rd || wr)) begin
      if (ready) begin
        wcnt <= 0;
        if (log_n < 64) begin
          log_wr[log_n]   <= wr;
          log_addr[log_n] <= addr;
          log_data[log_n] <= wr ? wdata : rdata;
          log_cyc[log_n]  <= cyc;
        end
        log_n <= log_n + 1;
        if (wr && addr == CTL_A) ctl_reg <= wdata;
        else if (wr && lane_of(addr) >= 0) lane_reg[lane_of(addr)] <= wdata;
        if (rd && addr == STS_A) sts_reads <= sts_reads + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  initial begin
    done_cnt = 0; err_cnt = 0; done_at = 0; err_at = 0; both_cnt = 0;
  end
  always @(negedge clk) begin
    if (done) begin done_cnt <= done_cnt + 1; done_at <= cyc; end
    if (err)  begin err_cnt <= err_cnt + 1; err_at <= cyc; end
    if (rd && wr) both_cnt <= both_cnt + 1;
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] adj(logic [31:0] w, int s);
    int c;
    c = int'(w[15:8]) + s;
    if (c < 0) c = 0;
    if (c > 255) c = 255;
    return {w[31:16], 8'(c), w[7:0]};
  endfunction

  // expected log
  bit e_wr [64];
  logic [15:0] e_addr [64];
  logic [31:0] e_data [64];
  int e_n;

  task automatic add(bit w, logic [15:0] a, logic [31:0] d);
    e_wr[e_n] = w; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
  endtask

  task automatic run_case(string tag, int lanes, int stp, int waits, int vtl, int lim,
                          bit exp_fail, int restart_at);
    int d0, e0, n, eff_lim, nclr, eff_lanes, t;
    bit fin;
    @(negedge clk);
    wait_n = waits; vt_lat = vtl; model_load = 1'b1;
    @(negedge clk);
    model_load = 1'b0;
    d0 = done_cnt; e0 = err_cnt;
    lane_cnt = 3'(lanes); step = 9'(stp); limit = 16'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fin = 0; t = 0;
    while (!fin && t < 3000) begin
      if (restart_at > 0 && t == restart_at) begin
        lane_cnt = 3'd1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      t++;
      if (done || err) fin = 1;
    end
    start = 1'b0;
    repeat (12) @(negedge clk);
    // expected sequence
    e_n = 0;
    eff_lim = (lim == 0) ? 1 : lim;
    nclr = exp_fail ? eff_lim : vtl;
    eff_lanes = (lanes > 4) ? 4 : lanes;
    add(0, CTL_A, cfg_ctl);
    add(1, CTL_A, cfg_ctl | (32'h1 << INH));
    for (int i = 0; i < nclr; i++) add(0, STS_A, 32'h1);
    if (!exp_fail) begin
      add(0, STS_A, 32'h1 | (32'h1 << VTS));
      for (int k = 0; k < eff_lanes; k++) begin
        add(0, 16'(16'h01C0 + k * 16'h0040), cfg_lane[k]);
        add(1, 16'(16'h01C0 + k * 16'h0040), adj(cfg_lane[k], stp));
        add(0, 16'(16'h01C0 + k * 16'h0040), adj(cfg_lane[k], stp));
      end
      add(1, CTL_A, cfg_ctl & ~(32'h1 << INH));
    end
    n = log_n;
    check(n == e_n, exp_fail ? "R10" : "R4", {tag, " transfer count"}, 32'(n), 32'(e_n));
    for (int i = 0; i < e_n && i < n; i++) begin
      string rq;
      if (e_addr[i] == CTL_A) rq = (i == 0 || i == 1) ? "R2" : "R7";
      else if (e_addr[i] == STS_A) rq = "R3";
      else rq = e_wr[i] ? "R5/R6" : "R4";
      check(log_wr[i] == e_wr[i] && log_addr[i] == e_addr[i], rq,
            $sformatf("%s xfer %0d kind/addr", tag, i),
            {15'd0, log_wr[i], log_addr[i]}, {15'd0, e_wr[i], e_addr[i]});
      check(log_data[i] == e_data[i], rq, $sformatf("%s xfer %0d data", tag, i),
            log_data[i], e_data[i]);
    end
    if (exp_fail) begin
      check(err_cnt - e0 == 1, "R10", {tag, " err pulses"}, 32'(err_cnt - e0), 1);
      check(done_cnt == d0, "R10", {tag, " no done"}, 32'(done_cnt - d0), 0);
      if (n > 0) check(err_at == log_cyc[n-1] + 1, "R10", {tag, " err timing"},
                       32'(err_at), 32'(log_cyc[n-1] + 1));
      check(ctl_reg[INH] == 1'b1, "R10", {tag, " inhibit left set"}, 32'(ctl_reg[INH]), 1);
    end else begin
      check(done_cnt - d0 == 1, restart_at > 0 ? "R9" : "R8", {tag, " done pulses"},
            32'(done_cnt - d0), 1);
      check(err_cnt == e0, "R8", {tag, " no err"}, 32'(err_cnt - e0), 0);
      if (n > 0) check(done_at == log_cyc[n-1] + 1, "R8", {tag, " done timing"},
                       32'(done_at), 32'(log_cyc[n-1] + 1));
      check(ctl_reg[INH] == 1'b0, "R7", {tag, " inhibit cleared"}, 32'(ctl_reg[INH]), 0);
    end
    check(busy == 1'b0, "R8", {tag, " idle after"}, 32'(busy), 0);
  endtask

  task automatic t_reset();
    check({busy, done, err, rd, wr} == 5'b0, "R1", "reset outputs",
          {27'd0, busy, done, err, rd, wr}, 0);
  endtask

  task automatic t_step_down();
    cfg_lane[0] = 32'h1234_0256; cfg_lane[1] = 32'hA5A5_80C3;
    cfg_lane[2] = 32'hFFFF_FF00; cfg_lane[3] = 32'h0000_0400;
    run_case("R5 step -4", 4, -4, 0, 2, 8, 0, 0);
  endtask

  task automatic t_step_up();
    cfg_lane[0] = 32'h0F0F_F011; cfg_lane[1] = 32'h7070_1022; cfg_lane[2] = 32'h0000_9B00;
    run_case("R5 step +100 waits", 3, 100, 2, 0, 4, 0, 0);
  endtask

  task automatic t_extremes();
    cfg_lane[0] = 32'hCAFE_0001; cfg_lane[1] = 32'hBEEF_FFFF;
    run_case("R5 step -256", 2, -256, 1, 1, 5, 0, 0);
    run_case("R5 step +255", 2, 255, 0, 0, 1, 0, 0);
  endtask

  task automatic t_zero_lanes();
    run_case("R4 zero lanes", 0, 5, 1, 3, 10, 0, 0);
  endtask

  task automatic t_cap_lanes();
    for (int i = 0; i < 8; i++) cfg_lane[i] = 32'h1111_0000 + 32'(i * 32'h1101);
    run_case("R4 lane cap", 6, 7, 0, 0, 2, 0, 0);
  endtask

  task automatic t_restart();
    cfg_lane[0] = 32'h0000_4000; cfg_lane[1] = 32'h0000_5000; cfg_lane[2] = 32'h0000_6000;
    run_case("R9 start while busy", 3, -16, 1, 1, 4, 0, 4);
  endtask

  task automatic t_timeout();
    run_case("R10 limit 3", 2, 1, 1, 100, 3, 1, 0);
    run_case("R10 limit 0", 2, 1, 0, 100, 0, 1, 0);
    cfg_lane[0] = 32'h0000_2000;
    run_case("R10 recover", 1, 1, 0, 0, 2, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_step_down();
    t_step_up();
    t_extremes();
    t_zero_lanes();
    t_cap_lanes();
    t_restart();
    t_timeout();
    check(both_cnt == 0, "R11", "both strobes seen", 32'(both_cnt), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule